// File: doc/BRIEF.md
# Pseudo-Random Noise Voice

This block is the noise voice of a retro console sound unit. A 15-bit linear feedback shift register steps once per period of a countdown timer. Each clock of `clk` counts as one CPU cycle. The timer reload comes from a fixed set of sixteen periods, picked by a 4-bit rate index. A mode bit selects the feedback tap. The long setting gives hiss-like white noise. The short setting gives a brief repeating sequence with a metallic, tonal character.

The output is a 4-bit sample. It carries the programmed volume while the register's low bit is clear and is zero while that bit is set. A host programs the voice through two 8-bit write-only registers, selected by a one-bit address:

- **Volume register:** `wrAddr` = 0, volume in bits 3:0.
- **Control register:** `wrAddr` = 1, mode in bit 7 (1 = short) and rate index in bits 3:0.

Top module: `noise_channel`

## Requirements
- R1: While `rstN` is low, `sampleOut` is 0. Reset sets the LFSR to 1, the volume to 0, the mode to long, the rate index to 0 and the timer to 0.
- R2: A write with `wrAddr` = 0 stores `wrData[3:0]` as the volume. Bits 7:4 of that write have no effect.
- R3: A write with `wrAddr` = 1 stores `wrData[7]` as the mode (1 = short) and `wrData[3:0]` as the rate index. Bits 6:4 have no effect.
- R4: In long mode a shift moves the 15-bit register right by one and puts bit0 XOR bit1 into bit 14.
- R5: In short mode the value placed into bit 14 is bit0 XOR bit6.
- R6: The rate indices 0 to 15 select periods of 4, 8, 16, 32, 64, 96, 128, 160, 202, 254, 380, 508, 762, 1016, 2034 and 4068 cycles.
- R7: A shift happens on each clock where the timer is 0, and the timer then reloads to period-1; on other clocks it decrements. The first shift comes on the first clock after reset is released. A new rate index is used at the next reload.
- R8: `sampleOut` is 0 when LFSR bit0 is 1, and otherwise equals the stored volume. A volume write shows on the next cycle.
- R9: A mode change does not reload the LFSR. It takes effect on the next shift, and the register never becomes all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one CPU cycle per edge |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 1 | 0 = volume register, 1 = control register |
| wrData | input | 8 | Write data |
| sampleOut | output | 4 | Gated volume sample |

## Verification
A wrong tap, a wrong shift direction or a lost register state puts a different bit into the low position within a few shifts. The gated output then departs from the expected volume-or-zero pattern. At the fastest rate that happens within tens of cycles. A wrong period table entry or an off-by-one reload moves the shift instants. The first toggle of the sample then lands a cycle or more away from its expected clock, so it is seen within one period of the selected rate. Comparing the sample on every clock against an independent model catches each of these at the first cycle they differ.

// File: rtl/noise_pkg.sv
package noise_pkg;
  localparam int PERIOD_W = 12;
  localparam int RATE_W   = 4;

  typedef struct packed {
    logic shift;
    logic shortMode;
  } noiseStrobes_t;

  function automatic logic [PERIOD_W-1:0] periodOf(input logic [RATE_W-1:0] rate);
    logic [PERIOD_W-1:0] p;
    case (rate)
      4'd0:  p = 12'd4;
      4'd1:  p = 12'd8;
      4'd2:  p = 12'd16;
      4'd3:  p = 12'd32;
      4'd4:  p = 12'd64;
      4'd5:  p = 12'd96;
      4'd6:  p = 12'd128;
      4'd7:  p = 12'd160;
      4'd8:  p = 12'd202;
      4'd9:  p = 12'd254;
      4'd10: p = 12'd380;
      4'd11: p = 12'd508;
      4'd12: p = 12'd762;
      4'd13: p = 12'd1016;
      4'd14: p = 12'd2034;
      default: p = 12'd4068;
    endcase
    return p;
  endfunction
endpackage

// File: rtl/noise_ctrl.sv
module noise_ctrl
  import noise_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int VOL_W    = 4,
  parameter int MODE_BIT = 7
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic                wrAddr,
  input  logic [DATA_W-1:0]   wrData,
  output noiseStrobes_t       strobes,
  output logic [VOL_W-1:0]    volume
);
  logic [PERIOD_W-1:0] timer;
  logic [RATE_W-1:0]   rateIdx;
  logic                modeReg;
  logic [VOL_W-1:0]    volReg;
  logic                timerDone;

  assign timerDone = (timer == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timer   <= '0;
      rateIdx <= '0;
      modeReg <= 1'b0;
      volReg  <= '0;
    end else begin
      if (timerDone) timer <= periodOf(rateIdx) - PERIOD_W'(1);
      else           timer <= timer - PERIOD_W'(1);
      if (wrEn) begin
        if (!wrAddr) begin
          volReg <= wrData[VOL_W-1:0];
        end else begin
          modeReg <= wrData[MODE_BIT];
          rateIdx <= wrData[RATE_W-1:0];
        end
      end
    end
  end

  always_comb begin
    strobes.shift     = timerDone;
    strobes.shortMode = modeReg;
    volume            = volReg;
  end

  // R7: a non-zero timer counts down by exactly one
  assert_timer_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    (timer != '0) |=> (timer == $past(timer) - PERIOD_W'(1)));

  // R2: a volume write lands on the next cycle
  assert_vol_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrAddr) |=> (volReg == $past(wrData[VOL_W-1:0])));

  // R3: a control write stores mode and rate
  assert_ctrl_write_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr) |=> (modeReg == $past(wrData[MODE_BIT]) && rateIdx == $past(wrData[RATE_W-1:0])));
endmodule

// File: rtl/noise_datapath.sv
module noise_datapath
  import noise_pkg::*;
#(
  parameter int LFSR_W    = 15,
  parameter int LONG_TAP  = 1,
  parameter int SHORT_TAP = 6,
  parameter int VOL_W     = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  noiseStrobes_t     strobes,
  input  logic [VOL_W-1:0]  volume,
  output logic [VOL_W-1:0]  sampleOut
);
  localparam logic [LFSR_W-1:0] SEED = LFSR_W'(1);

  logic [LFSR_W-1:0] lfsr;
  logic              feedback;

  always_comb begin
    feedback = lfsr[0] ^ (strobes.shortMode ? lfsr[SHORT_TAP] : lfsr[LONG_TAP]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             lfsr <= SEED;
    else if (strobes.shift) lfsr <= {feedback, lfsr[LFSR_W-1:1]};
  end

  always_comb sampleOut = lfsr[0] ? '0 : volume;

  // R4: long-mode feedback enters the top bit
  assert_long_tap_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.shift && !strobes.shortMode) |=>
      (lfsr[LFSR_W-1] == ($past(lfsr[0]) ^ $past(lfsr[LONG_TAP]))));

  // R5: short-mode feedback enters the top bit
  assert_short_tap_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.shift && strobes.shortMode) |=>
      (lfsr[LFSR_W-1] == ($past(lfsr[0]) ^ $past(lfsr[SHORT_TAP]))));

  // R7: without a shift strobe the register holds
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.shift |=> $stable(lfsr));

  // R9: mode switching never collapses the register to zero
  assert_alive_R9: assert property (@(posedge clk) disable iff (!rstN)
    lfsr != '0);
endmodule

// File: rtl/noise_channel.sv
module noise_channel
  import noise_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int VOL_W  = 4,
  parameter int LFSR_W = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [VOL_W-1:0]  sampleOut
);
  noiseStrobes_t    strobes;
  logic [VOL_W-1:0] volume;

  noise_ctrl #(.DATA_W(DATA_W), .VOL_W(VOL_W), .MODE_BIT(DATA_W-1)) i_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .strobes(strobes), .volume(volume)
  );

  noise_datapath #(.LFSR_W(LFSR_W), .LONG_TAP(1), .SHORT_TAP(6), .VOL_W(VOL_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .volume(volume), .sampleOut(sampleOut)
  );
endmodule

// File: tb/test_noise_channel.sv
module test_noise_channel;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic       wrAddr = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [3:0] sampleOut;

  always #4 clk = ~clk;

  noise_channel i_noise_channel (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .sampleOut(sampleOut)
  );

  int    vectors = 0;
  int    miscompares = 0;
  string tag = "R1";
  bit    checking = 1'b0;
  bit    done = 1'b0;

  int mLfsr = 1, mTimer = 0, mVol = 0, mMode = 0, mIdx = 0;

  function automatic int periodRef(input int i);
    int t[16] = '{4, 8, 16, 32, 64, 96, 128, 160, 202, 254, 380, 508, 762, 1016, 2034, 4068};
    return t[i];
  endfunction

  // behavioural reference, advanced once per clock
  always @(posedge clk) begin
    if (!rstN) begin
      mLfsr = 1; mTimer = 0; mVol = 0; mMode = 0; mIdx = 0;
    end else begin
      if (mTimer == 0) begin
        int fb;
        mTimer = periodRef(mIdx) - 1;
        fb = (mLfsr & 1) ^ ((mLfsr >> (mMode ? 6 : 1)) & 1);
        mLfsr = (mLfsr >> 1) | (fb << 14);
      end else begin
        mTimer = mTimer - 1;
      end
      if (wrEn) begin
        if (wrAddr == 1'b0) mVol = wrData & 15;
        else begin
          mMode = wrData[7];
          mIdx = wrData & 15;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (checking && !done) begin
      int expv;
      expv = (mLfsr & 1) ? 0 : mVol;
      vectors++;
      if (sampleOut !== 4'(expv)) begin
        miscompares++;
        $display("FAIL %s: sampleOut=%0d expected=%0d at %0t", tag, sampleOut, expv, $time);
      end
    end
  end

  task automatic writeReg(input logic a, input logic [7:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = 8'h00;
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: run did not end, actual=hung expected=finished");
    finishRun();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    vectors++;
    if (sampleOut !== 4'd0) begin
      miscompares++;
      $display("FAIL R1: sampleOut=%0d expected=0 in reset", sampleOut);
    end
    rstN = 1'b1;
    checking = 1'b1;
    tag = "R1"; repeat (10) @(negedge clk);

    tag = "R2"; writeReg(1'b0, 8'hF7); repeat (100) @(negedge clk);
    tag = "R4"; writeReg(1'b0, 8'h0F); writeReg(1'b1, 8'h00); repeat (400) @(negedge clk);

    for (int i = 0; i < 16; i++) begin
      tag = "R6";
      writeReg(1'b1, 8'(i));
      repeat (3 * periodRef(i) + 5) @(negedge clk);
    end

    tag = "R7"; writeReg(1'b1, 8'h02); repeat (7) @(negedge clk);
    writeReg(1'b1, 8'h00); repeat (60) @(negedge clk);

    tag = "R5"; writeReg(1'b1, 8'h81); repeat (2000) @(negedge clk);
    tag = "R3"; writeReg(1'b1, 8'hF0); repeat (300) @(negedge clk);
    writeReg(1'b1, 8'h71); repeat (300) @(negedge clk);

    tag = "R9";
    for (int k = 0; k < 30; k++) begin
      writeReg(1'b1, (k % 2 == 0) ? 8'h80 : 8'h00);
      repeat (37) @(negedge clk);
    end

    tag = "R8";
    for (int v = 0; v < 16; v++) begin
      writeReg(1'b0, 8'(v));
      repeat (13) @(negedge clk);
    end

    finishRun();
  end
endmodule